// File: doc/BRIEF.md
# Systolic Conditional-Adder Sieve Pipeline

This block scores a range of consecutive integer locations against a set of arithmetic progressions. Each of the `NSTAGE` pipeline stages owns one progression, given by a modulus, a residue and a small integer weight. The weight is normally the rounded logarithm of the modulus, and it is computed outside the block. A narrow accumulation bus runs through the chain of stages. Location `a` enters stage 0 in cycle `a` of a run and moves forward one stage per cycle. A stage adds its weight to the passing sum when `a` falls in its progression. The stage decides this with its own countdown timer, so no divider is needed and no central accumulator array exists.

After the last stage, a threshold unit compares each finished sum with a threshold that is captured at run start. It raises a report for every location whose score is strictly above that threshold. Reports come out in ascending location order, at most one per cycle. When the pipeline has drained, a one-cycle done pulse closes the run.

Progression parameters are shifted in through a valid/ready port while the block is idle. That port accepts a word on every cycle in which `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low for the whole of a run, so a word offered then waits and is not lost. The report stream is valid-only. It has no ready because the systolic chain cannot stall, so the consumer must take a report on every cycle that `rpt_valid` is high.

Top module: `sieve_pipe`

## Requirements
- R1: After reset, `rpt_valid` and `done` are 0 and `cfg_ready` is 1.
- R2: Configuration words are 32 bits: modulus in [31:20], residue in [19:8], weight in [7:0].
  - A word is accepted when `cfg_valid` and `cfg_ready` are both high. It enters stage 0 and pushes every stored word one stage onward.
  - `cfg_ready` is 0 from the run-start edge until the done cycle. During that time, words offered on the port leave the stored configuration unchanged.
- R3: `start` while idle begins a run and captures `threshold` and `run_len`. `start` during a run has no effect on that run's reports or timing.
- R4: For location `a`, a stage with modulus m ≥ 1 and residue r < m contributes its weight exactly when `a mod m == r`.
- R5: A location's score is the sum of the contributing weights, clipped at 1023. The bus saturates and never wraps.
- R6: `rpt_valid` is high for location `a` exactly when its score is strictly greater than the threshold, and `rpt_loc` equals `a` in that cycle.
- R7: The report slot for location `a` is cycle `a + NSTAGE + 1` after the start edge. Slots are in ascending order, one location per cycle, for `a = 0 .. run_len-1`.
- R8: `done` is high for exactly one cycle, cycle `run_len + NSTAGE` after the start edge. This is the same cycle as the last report slot, and `cfg_ready` is already 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Block is idle and accepts configuration |
| cfg_data | input | 32 | Configuration word {modulus, residue, weight} |
| start | input | 1 | Run start strobe (honoured only when idle) |
| threshold | input | 10 | Report threshold, captured at start |
| run_len | input | 16 | Number of locations in the run, captured at start, at least 1 |
| rpt_valid | output | 1 | A location scored above the threshold |
| rpt_loc | output | 16 | Index of the reported location |
| done | output | 1 | One-cycle pulse when the run has drained |

## Verification
Cycles are counted from the edge that samples `start`.
- The report for location `a` is due in cycle `a + NSTAGE + 1`. The bench computes that location's score from its own copy of the progressions and samples `rpt_valid` and `rpt_loc` at the falling edge of that cycle.
- Every cycle of the run window is checked, so a report that is missing, extra or shifted by one cycle is caught.
- `done` must be high only in cycle `run_len + NSTAGE`. One cycle later the bench checks that `done` has fallen and `cfg_ready` is high.
- In a repeated run, the bench drives configuration words and `start` throughout the run. The reports must match those of the undisturbed run exactly.

// File: rtl/sieve_pkg.sv
package sieve_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sieve_seq.sv
module sieve_seq
  import sieve_pkg::*;
#(
  parameter int LOC_W  = 16,
  parameter int NSTAGE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LOC_W-1:0] run_len,
  output logic             idle,
  output logic             launch,
  output logic             inj_valid,
  output logic [LOC_W-1:0] inj_loc,
  output logic             done
);
  localparam int DRN_W = $clog2(NSTAGE + 1);

  seq_state_e       state_q;
  logic [LOC_W-1:0] next_loc_q;
  logic [LOC_W-1:0] len_q;
  logic [DRN_W-1:0] drain_q;

  assign idle      = (state_q == SQ_IDLE);
  assign launch    = start && idle;
  assign inj_valid = (state_q == SQ_RUN) && (next_loc_q != len_q);
  assign inj_loc   = next_loc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      next_loc_q <= '0;
      len_q      <= '0;
      drain_q    <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            len_q      <= run_len;
            next_loc_q <= '0;
            state_q    <= SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (inj_valid) next_loc_q <= next_loc_q + 1'b1;
          if (!inj_valid || (next_loc_q + 1'b1 == len_q)) begin
            state_q <= SQ_DRAIN;
            drain_q <= '0;
          end
        end
        SQ_DRAIN: begin
          if (drain_q == DRN_W'(NSTAGE - 1)) begin
            state_q <= SQ_IDLE;
            done    <= 1'b1;
          end else begin
            drain_q <= drain_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle); // R8
  AST_INJECT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && $past(inj_valid) |-> inj_loc == LOC_W'($past(inj_loc) + 1'b1)); // R7
endmodule

// File: rtl/sieve_stage.sv
module sieve_stage #(
  parameter int MOD_W = 12,
  parameter int WGT_W = 8,
  parameter int BUS_W = 10,
  parameter int LOC_W = 16,
  localparam int CFG_W = 2 * MOD_W + WGT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [CFG_W-1:0] cfg_in,
  output logic [CFG_W-1:0] cfg_out,
  input  logic             launch,
  input  logic             in_valid,
  input  logic [LOC_W-1:0] in_loc,
  input  logic [BUS_W-1:0] in_sum,
  output logic             out_valid,
  output logic [LOC_W-1:0] out_loc,
  output logic [BUS_W-1:0] out_sum
);
  logic [CFG_W-1:0] cfg_q;
  logic [MOD_W-1:0] modulus, residue, tmr_q;
  logic [WGT_W-1:0] weight;
  logic             hit;
  logic [BUS_W:0]   wide_sum;
  logic [BUS_W-1:0] sat_sum;

  assign cfg_out = cfg_q;
  assign modulus = cfg_q[CFG_W-1 -: MOD_W];
  assign residue = cfg_q[WGT_W +: MOD_W];
  assign weight  = cfg_q[WGT_W-1:0];

  assign hit      = in_valid && (tmr_q == '0);
  assign wide_sum = {1'b0, in_sum} + (hit ? (BUS_W+1)'(weight) : '0);
  assign sat_sum  = wide_sum[BUS_W] ? '1 : wide_sum[BUS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (shift_en) cfg_q <= cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else if (launch) tmr_q <= residue;
    else if (in_valid) tmr_q <= (tmr_q == '0) ? modulus - 1'b1 : tmr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_loc   <= '0;
      out_sum   <= '0;
    end else if (launch) begin
      out_valid <= 1'b0;
      out_loc   <= '0;
      out_sum   <= '0;
    end else begin
      out_valid <= in_valid;
      out_loc   <= in_loc;
      out_sum   <= in_valid ? sat_sum : '0;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !launch |=> out_sum >= $past(in_sum)); // R5
  AST_LOC_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !launch |=> out_valid && out_loc == $past(in_loc)); // R7
endmodule

// File: rtl/sieve_thresh.sv
module sieve_thresh #(
  parameter int BUS_W = 10,
  parameter int LOC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [BUS_W-1:0] threshold,
  input  logic             in_valid,
  input  logic [LOC_W-1:0] in_loc,
  input  logic [BUS_W-1:0] in_sum,
  output logic             rpt_valid,
  output logic [LOC_W-1:0] rpt_loc
);
  logic [BUS_W-1:0] thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q     <= '0;
      rpt_valid <= 1'b0;
      rpt_loc   <= '0;
    end else if (launch) begin
      thr_q     <= threshold;
      rpt_valid <= 1'b0;
    end else begin
      rpt_valid <= in_valid && (in_sum > thr_q);
      rpt_loc   <= in_loc;
    end
  end

  AST_REPORT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && $past(rpt_valid) |-> rpt_loc == LOC_W'($past(rpt_loc) + 1'b1)); // R7
endmodule

// File: rtl/sieve_pipe.sv
module sieve_pipe #(
  parameter int NSTAGE = 8,
  parameter int MOD_W  = 12,
  parameter int WGT_W  = 8,
  parameter int BUS_W  = 10,
  parameter int LOC_W  = 16,
  localparam int CFG_W = 2 * MOD_W + WGT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             start,
  input  logic [BUS_W-1:0] threshold,
  input  logic [LOC_W-1:0] run_len,
  output logic             rpt_valid,
  output logic [LOC_W-1:0] rpt_loc,
  output logic             done
);
  logic             idle, launch, shift_en;
  logic [CFG_W-1:0] cfg_link [NSTAGE+1];
  logic             v_link   [NSTAGE+1];
  logic [LOC_W-1:0] loc_link [NSTAGE+1];
  logic [BUS_W-1:0] sum_link [NSTAGE+1];

  assign cfg_ready   = idle;
  assign shift_en    = cfg_valid && idle;
  assign cfg_link[0] = cfg_data;
  assign sum_link[0] = '0;

  sieve_seq #(.LOC_W(LOC_W), .NSTAGE(NSTAGE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len),
    .idle(idle), .launch(launch), .inj_valid(v_link[0]),
    .inj_loc(loc_link[0]), .done(done)
  );

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    sieve_stage #(.MOD_W(MOD_W), .WGT_W(WGT_W), .BUS_W(BUS_W), .LOC_W(LOC_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
      .cfg_in(cfg_link[g]), .cfg_out(cfg_link[g+1]),
      .launch(launch),
      .in_valid(v_link[g]), .in_loc(loc_link[g]), .in_sum(sum_link[g]),
      .out_valid(v_link[g+1]), .out_loc(loc_link[g+1]), .out_sum(sum_link[g+1])
    );
  end

  sieve_thresh #(.BUS_W(BUS_W), .LOC_W(LOC_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .launch(launch), .threshold(threshold),
    .in_valid(v_link[NSTAGE]), .in_loc(loc_link[NSTAGE]), .in_sum(sum_link[NSTAGE]),
    .rpt_valid(rpt_valid), .rpt_loc(rpt_loc)
  );

  AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(cfg_link[NSTAGE])); // R2
endmodule

// File: tb/sieve_pipe_test.sv
module sieve_pipe_test;
  localparam int NST = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [31:0] cfg_data = '0;
  logic        start = 1'b0;
  logic [9:0]  threshold = '0;
  logic [15:0] run_len = '0;
  logic        rpt_valid;
  logic [15:0] rpt_loc;
  logic        done;

  int errs = 0;
  int checks = 0;
  int mods [NST];
  int ress [NST];
  int wts  [NST];
  bit finished = 1'b0;

  sieve_pipe uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_data(cfg_data), .start(start), .threshold(threshold), .run_len(run_len),
    .rpt_valid(rpt_valid), .rpt_loc(rpt_loc), .done(done)
  );

  always #10 clk = ~clk;

  function automatic int score(int a);
    int s = 0;
    for (int i = 0; i < NST; i++)
      if (a % mods[i] == ress[i]) s += wts[i];
    return (s > 1023) ? 1023 : s;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(int i, int m, int r, int w);
    @(negedge clk);
    check(cfg_ready == 1'b1, "R2", "cfg_ready while idle", int'(cfg_ready), 1);
    cfg_valid = 1'b1;
    cfg_data  = {m[11:0], r[11:0], w[7:0]};
    mods[i] = m; ress[i] = r; wts[i] = w;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic run(int thr, int rl, bit disturb);
    @(negedge clk);
    threshold = thr[9:0];
    run_len   = rl[15:0];
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= rl + NST; k++) begin
      int  a;
      bit  ev;
      @(negedge clk);
      a  = k - NST - 1;
      ev = (a >= 0) && (a < rl) && (score(a) > thr);
      check(rpt_valid == ev, "R6", $sformatf("rpt_valid loc %0d", a), int'(rpt_valid), int'(ev));
      if (ev)
        check(rpt_loc == a[15:0], "R7", "rpt_loc", int'(rpt_loc), a);
      check(done == (k == rl + NST), "R8", $sformatf("done in cycle %0d", k), int'(done),
            int'(k == rl + NST));
      if (k < rl + NST)
        check(cfg_ready == 1'b0, "R2", "cfg_ready during run", int'(cfg_ready), 0);
      if (disturb && k < rl + NST - 1) begin
        cfg_valid = 1'b1;
        cfg_data  = $urandom;
        start     = $urandom_range(0, 1);
      end else begin
        cfg_valid = 1'b0;
        start     = 1'b0;
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R8", "done falls", int'(done), 0);
    check(cfg_ready == 1'b1, "R8", "cfg_ready after done", int'(cfg_ready), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    int dm [NST] = '{2, 3, 5, 7, 4, 6, 9, 1};
    int dr [NST] = '{0, 1, 2, 3, 1, 5, 8, 0};
    int dw [NST] = '{3, 4, 5, 6, 2, 7, 9, 1};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rpt_valid == 1'b0, "R1", "rpt_valid in reset", int'(rpt_valid), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(cfg_ready == 1'b1, "R1", "cfg_ready in reset", int'(cfg_ready), 1);
    rst_n = 1'b1;

    // R4 R6 R7: directed mixed moduli
    for (int i = 0; i < NST; i++) load(i, dm[i], dr[i], dw[i]);
    run(10, 48, 1'b0);
    // R2 R3: same run with config words and start strobes pushed while busy
    run(10, 48, 1'b1);
    run(10, 48, 1'b0);

    // R5: saturation, every stage hits every location with weight 200
    for (int i = 0; i < NST; i++) load(i, 1, 0, 200);
    run(1022, 5, 1'b0);
    run(1023, 5, 1'b0);

    // R4 R6: random progressions, thresholds and lengths
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < NST; i++) begin
        int m = $urandom_range(1, 20);
        load(i, m, $urandom_range(0, m - 1), $urandom_range(0, 60));
      end
      run($urandom_range(0, 150), $urandom_range(30, 80), t[0]);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule